// File: doc/BRIEF.md
# Run Label Equivalence Resolver

This block takes a table of pixel runs that already carry provisional labels and settles every label conflict among them. Each run holds an identity, an equivalence, a first column, a last column and a row. A conflict is a run whose identity and equivalence differ. For each such run, the block sweeps the whole table once. Every identity that matches the conflicting identity is rewritten to the equivalence, and every equivalence that matches it is rewritten the same way. Both rewrites are done in a single cycle per visited run. After one outer pass over the table, the resolved labels are emitted as pixel writes for a label image.

The write-back runs in two phases. The first clears every pixel of the image to the background label 0. The second expands each run, in table order, into one write per covered pixel, using the run's final identity as the label. No pass over the image is needed to find the pixels, because each run carries its own row and column span. The write channel is valid/ready. A beat transfers on a clock edge where both valid and ready are high. While ready is low, the beat stays presented unchanged, and the block stalls without losing or repeating pixels. The run table is loaded beforehand through a separate valid/ready port, which accepts entries only while the block is idle.

Top module: `rle_resolver`

## Requirements
- R1: `load_ready` is high exactly when `busy` is low. An entry (identity, equivalence, first column, last column, row, with first column ≤ last column) is written at index `load_idx` on an edge where `load_valid` and `load_ready` are both high. A load offered while busy leaves the table unchanged.
- R2: `start` is taken only while idle; it latches `run_count` and raises `busy` on the following cycle. A `start` while busy has no effect on the write sequence.
- R3: The outer pass visits runs 0 to `run_count`-1 in order. A run whose identity equals its equivalence costs one cycle. A run that conflicts costs one cycle plus one cycle per table entry. With `run_count` ≥ 1, the first write beat is presented exactly `run_count` × (1 + conflicts) + 1 cycles after the edge that took `start`.
- R4: For a conflicting run, its identity (T) and equivalence (Q) at the moment it is visited are captured. Every run j in 0..`run_count`-1 is then visited once.
- R5: In each inner visit, a run whose identity equals T gets identity Q, and a run whose equivalence equals T gets equivalence Q. Both rewrites happen in the same cycle, and both may apply to one run.
- R6: T and Q stay fixed during the inner sweep, even when the sweep rewrites the conflicting run itself.
- R7: The first `IMG_W`×`IMG_H` beats carry addresses 0, 1, 2 … in ascending order, all with label 0.
- R8: The clear phase is followed by the span phase. For each run in index order, it emits addresses row×`IMG_W`+column, for columns from first to last ascending, each labelled with that run's resolved identity.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_label` hold their values on the next cycle.
- R10: `done` rises on the cycle after the final beat is accepted. It stays high with `busy` low until the next accepted `start` clears it.
- R11: Two arms labelled 1 and 2 joined by a lower run (identity 1, equivalence 2) resolve so that all four runs carry label 2.
- R12: With `run_count` 0, only the clear phase is emitted, then `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_valid | input | 1 | Table entry offered |
| load_ready | output | 1 | Table accepts entries (idle) |
| load_idx | input | 3 | Table index written |
| load_id | input | 4 | Provisional identity |
| load_eq | input | 4 | Provisional equivalence |
| load_start | input | 3 | First column of the run |
| load_end | input | 3 | Last column of the run |
| load_row | input | 2 | Row of the run |
| run_count | input | 4 | Number of valid runs, 0 to 8 |
| start | input | 1 | Begin resolution and write-back |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job complete |
| wr_valid | output | 1 | Pixel write offered |
| wr_ready | input | 1 | Pixel write accepted |
| wr_addr | output | 5 | Pixel address row×width+column |
| wr_label | output | 4 | Pixel label |

## Verification
Within one inner step, the identity rewrite and the equivalence rewrite can land on the same run in the same cycle. One chain table contains a run whose identity and equivalence both equal the captured conflict identity. The same table has another run where only the equivalence matches, and a later run whose identity matches only if the captured value is held rather than re-read from the rewritten entry. The bench judges the outcome from the labels that run's pixels receive in the span phase, which must match a bench model that applies both rewrites per step. The cycle count to the first beat confirms that each inner step took exactly one cycle.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {M_IDLE, M_OUTER, M_INNER} merge_st_e;
  typedef enum logic [1:0] {W_IDLE, W_CLEAR, W_SPAN} wb_st_e;
endpackage

// File: rtl/rle_run_table.sv
module rle_run_table #(
  parameter int NR = 8,
  parameter int IW = 3,
  parameter int LW = 4,
  parameter int XW = 3,
  parameter int YW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [LW-1:0] ld_id,
  input  logic [LW-1:0] ld_eq,
  input  logic [XW-1:0] ld_s,
  input  logic [XW-1:0] ld_e,
  input  logic [YW-1:0] ld_r,
  input  logic          mg_en,
  input  logic [IW-1:0] mg_idx,
  input  logic [LW-1:0] mg_tid,
  input  logic [LW-1:0] mg_teq,
  input  logic [IW-1:0] rd_idx,
  output logic [LW-1:0] rd_id,
  output logic [LW-1:0] rd_eq,
  output logic [XW-1:0] rd_s,
  output logic [XW-1:0] rd_e,
  output logic [YW-1:0] rd_r
);
  logic [LW-1:0] id_q [NR];
  logic [LW-1:0] eq_q [NR];
  logic [XW-1:0] s_q  [NR];
  logic [XW-1:0] e_q  [NR];
  logic [YW-1:0] r_q  [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NR; g++) begin
        id_q[g] <= '0;
        eq_q[g] <= '0;
        s_q[g]  <= '0;
        e_q[g]  <= '0;
        r_q[g]  <= '0;
      end
    end else begin
      for (int g = 0; g < NR; g++) begin
        if (ld_en && ld_idx == IW'(g)) begin
          id_q[g] <= ld_id;
          eq_q[g] <= ld_eq;
          s_q[g]  <= ld_s;
          e_q[g]  <= ld_e;
          r_q[g]  <= ld_r;
        end else if (mg_en && mg_idx == IW'(g)) begin
          // both rewrites judged against the pre-step values in one cycle
          if (id_q[g] == mg_tid) id_q[g] <= mg_teq;
          if (eq_q[g] == mg_tid) eq_q[g] <= mg_teq;
        end
      end
    end
  end

  assign rd_id = id_q[rd_idx];
  assign rd_eq = eq_q[rd_idx];
  assign rd_s  = s_q[rd_idx];
  assign rd_e  = e_q[rd_idx];
  assign rd_r  = r_q[rd_idx];
endmodule

// File: rtl/rle_merge_seq.sv
module rle_merge_seq
  import rle_pkg::*;
#(
  parameter int IW = 3,
  parameter int CW = 4,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] rd_id,
  input  logic [LW-1:0] rd_eq,
  output logic [IW-1:0] outer_idx,
  output logic          mg_en,
  output logic [IW-1:0] mg_idx,
  output logic [LW-1:0] tid,
  output logic [LW-1:0] teq,
  output logic          fin,
  output logic          busy
);
  merge_st_e     st;
  logic [IW-1:0] i_q, j_q;
  logic          last_i, last_j;

  assign last_i = (CW'(i_q) + CW'(1)) == count;
  assign last_j = (CW'(j_q) + CW'(1)) == count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= M_IDLE;
      i_q <= '0;
      j_q <= '0;
      tid <= '0;
      teq <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        M_IDLE: if (go) begin
          st  <= M_OUTER;
          i_q <= '0;
        end
        M_OUTER: begin
          if (count == '0) begin
            fin <= 1'b1;
            st  <= M_IDLE;
          end else if (rd_id != rd_eq) begin
            tid <= rd_id;
            teq <= rd_eq;
            j_q <= '0;
            st  <= M_INNER;
          end else if (last_i) begin
            fin <= 1'b1;
            st  <= M_IDLE;
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        M_INNER: begin
          if (last_j) begin
            j_q <= '0;
            if (last_i) begin
              fin <= 1'b1;
              st  <= M_IDLE;
            end else begin
              i_q <= i_q + 1'b1;
              st  <= M_OUTER;
            end
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  assign outer_idx = i_q;
  assign mg_en     = (st == M_INNER);
  assign mg_idx    = j_q;
  assign busy      = (st != M_IDLE);
endmodule

// File: rtl/rle_span_writer.sv
module rle_span_writer
  import rle_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int PIX   = 32,
  parameter int AW    = 5,
  parameter int IW    = 3,
  parameter int CW    = 4,
  parameter int LW    = 4,
  parameter int XW    = 3,
  parameter int YW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          clr,
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] rd_id,
  input  logic [XW-1:0] rd_s,
  input  logic [XW-1:0] rd_e,
  input  logic [YW-1:0] rd_r,
  output logic [IW-1:0] run_idx,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] wr_label,
  output logic          done,
  output logic          busy
);
  wb_st_e        st;
  logic [AW-1:0] pix_q;
  logic [IW-1:0] k_q;
  logic [XW-1:0] x_q, x_eff;
  logic          fresh_q, last_k;

  assign x_eff  = fresh_q ? rd_s : x_q;
  assign last_k = (CW'(k_q) + CW'(1)) == count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      pix_q   <= '0;
      k_q     <= '0;
      x_q     <= '0;
      fresh_q <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (clr) done <= 1'b0;
      case (st)
        W_IDLE: if (go) begin
          st    <= W_CLEAR;
          pix_q <= '0;
        end
        W_CLEAR: if (wr_ready) begin
          if (pix_q == AW'(PIX - 1)) begin
            if (count == '0) begin
              st   <= W_IDLE;
              done <= 1'b1;
            end else begin
              st      <= W_SPAN;
              k_q     <= '0;
              fresh_q <= 1'b1;
            end
          end else begin
            pix_q <= pix_q + 1'b1;
          end
        end
        W_SPAN: if (wr_ready) begin
          if (x_eff == rd_e) begin
            fresh_q <= 1'b1;
            if (last_k) begin
              st   <= W_IDLE;
              done <= 1'b1;
            end else begin
              k_q <= k_q + 1'b1;
            end
          end else begin
            x_q     <= x_eff + 1'b1;
            fresh_q <= 1'b0;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign run_idx  = k_q;
  assign wr_valid = (st != W_IDLE);
  assign wr_addr  = (st == W_CLEAR) ? pix_q
                  : AW'(AW'(rd_r) * AW'(IMG_W) + AW'(x_eff));
  assign wr_label = (st == W_CLEAR) ? '0 : rd_id;
  assign busy     = (st != W_IDLE);
endmodule

// File: rtl/rle_resolver.sv
module rle_resolver #(
  parameter int MAX_RUNS = 8,
  parameter int IMG_W    = 8,
  parameter int IMG_H    = 4,
  parameter int LW       = 4,
  localparam int IW  = $clog2(MAX_RUNS),
  localparam int CW  = $clog2(MAX_RUNS + 1),
  localparam int XW  = $clog2(IMG_W),
  localparam int YW  = $clog2(IMG_H),
  localparam int PIX = IMG_W * IMG_H,
  localparam int AW  = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_valid,
  output logic          load_ready,
  input  logic [IW-1:0] load_idx,
  input  logic [LW-1:0] load_id,
  input  logic [LW-1:0] load_eq,
  input  logic [XW-1:0] load_start,
  input  logic [XW-1:0] load_end,
  input  logic [YW-1:0] load_row,
  input  logic [CW-1:0] run_count,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] wr_label
);
  logic          m_busy, m_fin, w_busy, mg_en, go;
  logic [IW-1:0] m_idx, mg_idx, w_idx, rd_idx;
  logic [LW-1:0] tid, teq, rd_id, rd_eq;
  logic [XW-1:0] rd_s, rd_e;
  logic [YW-1:0] rd_r;
  logic [CW-1:0] count_q;

  assign busy       = m_busy | m_fin | w_busy;
  assign load_ready = !busy;
  assign go         = start && !busy;
  assign rd_idx     = m_busy ? m_idx : w_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count_q <= '0;
    else if (go) count_q <= run_count;
  end

  rle_run_table #(.NR(MAX_RUNS), .IW(IW), .LW(LW), .XW(XW), .YW(YW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .ld_en(load_valid && load_ready), .ld_idx(load_idx), .ld_id(load_id),
    .ld_eq(load_eq), .ld_s(load_start), .ld_e(load_end), .ld_r(load_row),
    .mg_en(mg_en), .mg_idx(mg_idx), .mg_tid(tid), .mg_teq(teq),
    .rd_idx(rd_idx), .rd_id(rd_id), .rd_eq(rd_eq), .rd_s(rd_s),
    .rd_e(rd_e), .rd_r(rd_r)
  );

  rle_merge_seq #(.IW(IW), .CW(CW), .LW(LW)) u_merge (
    .clk(clk), .rst_n(rst_n), .go(go), .count(count_q),
    .rd_id(rd_id), .rd_eq(rd_eq), .outer_idx(m_idx),
    .mg_en(mg_en), .mg_idx(mg_idx), .tid(tid), .teq(teq),
    .fin(m_fin), .busy(m_busy)
  );

  rle_span_writer #(.IMG_W(IMG_W), .PIX(PIX), .AW(AW), .IW(IW), .CW(CW),
                    .LW(LW), .XW(XW), .YW(YW)) u_writer (
    .clk(clk), .rst_n(rst_n), .go(m_fin), .clr(go), .count(count_q),
    .rd_id(rd_id), .rd_s(rd_s), .rd_e(rd_e), .rd_r(rd_r),
    .run_idx(w_idx), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_label(wr_label), .done(done), .busy(w_busy)
  );
endmodule

// File: rtl/rle_resolver_chk.sv
module rle_resolver_chk #(
  parameter int AW = 5,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          load_ready,
  input logic          done,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [LW-1:0] wr_label
);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_label));

  a_r1_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !load_ready);

  a_r10_done_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_valid);

  a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_addr == '0 && wr_label == '0);

  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  a_r10_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid && wr_ready));
endmodule

bind rle_resolver rle_resolver_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .load_ready(load_ready), .done(done), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_label(wr_label)
);

// File: tb/tb_rle_resolver.sv
module tb_rle_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8, W = 8, H = 4, PIX = W * H, LW = 4;
  localparam int MAXB = PIX + NR * W;

  logic       clk = 0, rst_n = 0;
  logic       load_valid = 0, start = 0, wr_ready = 0;
  logic [2:0] load_idx = 0, load_start = 0, load_end = 0;
  logic [3:0] load_id = 0, load_eq = 0, run_count = 0;
  logic [1:0] load_row = 0;
  logic       load_ready, busy, done, wr_valid;
  logic [4:0] wr_addr;
  logic [3:0] wr_label;

  int errors = 0, checks = 0;
  int bid [NR], beq [NR], bs [NR], be [NR], br [NR];
  int exp_a [MAXB], exp_l [MAXB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rle_resolver dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_idx(load_idx), .load_id(load_id), .load_eq(load_eq),
    .load_start(load_start), .load_end(load_end), .load_row(load_row),
    .run_count(run_count), .start(start), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_label(wr_label)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_run(input int k, input int id, input int eq,
                         input int s, input int e, input int r);
    bid[k] = id; beq[k] = eq; bs[k] = s; be[k] = e; br[k] = r;
  endtask

  task automatic load_table(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(load_ready, "R1", "load_ready idle", load_ready, 1);
      load_valid = 1; load_idx = 3'(k); load_id = 4'(bid[k]);
      load_eq = 4'(beq[k]); load_start = 3'(bs[k]); load_end = 3'(be[k]);
      load_row = 2'(br[k]);
    end
    @(negedge clk);
    load_valid = 0;
  endtask

  // n runs; rmode 1 = ready gaps; poke = offer start/load mid-job
  task automatic run_job(input int n, input int rmode, input bit poke,
                         input string req);
    int mid [NR], meq [NR];
    int conf, ne, got, first, lat, tid, teq, pa, pl;
    bit pend;
    conf = 0; ne = 0; got = 0; first = -1; pend = 0; pa = 0; pl = 0;
    for (int k = 0; k < NR; k++) begin mid[k] = bid[k]; meq[k] = beq[k]; end
    for (int i = 0; i < n; i++) begin
      if (mid[i] != meq[i]) begin
        conf++; tid = mid[i]; teq = meq[i];
        for (int j = 0; j < n; j++) begin
          if (mid[j] == tid) mid[j] = teq;
          if (meq[j] == tid) meq[j] = teq;
        end
      end
    end
    lat = n * (1 + conf) + 1;
    for (int p = 0; p < PIX; p++) begin exp_a[ne] = p; exp_l[ne] = 0; ne++; end
    for (int k = 0; k < n; k++)
      for (int x = bs[k]; x <= be[k]; x++) begin
        exp_a[ne] = br[k] * W + x; exp_l[ne] = mid[k]; ne++;
      end
    @(negedge clk);
    run_count = 4'(n); start = 1;
    for (int cnt = 1; cnt < 3000; cnt++) begin
      @(negedge clk);
      if (cnt == 1) begin
        start = 0;
        chk(busy && !done, "R2", "busy after start, done cleared (R10)", {busy, done}, 2);
      end
      if (poke && cnt == 3) begin
        chk(!load_ready, "R1", "load_ready while busy", load_ready, 0);
        start = 1; run_count = 4'(1); load_valid = 1; load_idx = 0; load_id = 4'd15;
      end
      if (poke && cnt == 4) begin start = 0; load_valid = 0; end
      wr_ready = (rmode == 1) ? (cnt % 3 != 0) : 1'b1;
      if (pend)
        chk(wr_valid && wr_addr == 5'(pa) && wr_label == 4'(pl), "R9",
            "stalled beat held", {wr_valid, wr_addr}, {1'b1, 5'(pa)});
      if (wr_valid && first < 0) first = cnt;
      if (wr_valid && wr_ready) begin
        chk(wr_addr == 5'(exp_a[got]) && wr_label == 4'(exp_l[got]), req,
            $sformatf("beat %0d addr*16+label", got), wr_addr * 16 + wr_label,
            exp_a[got] * 16 + exp_l[got]);
        got++;
        if (got == ne) begin
          chk(!done, "R10", "done low before last accept", done, 0);
          break;
        end
      end
      pend = wr_valid && !wr_ready;
      pa = wr_addr; pl = wr_label;
    end
    @(negedge clk);
    wr_ready = 0;
    chk(got == ne, req, "beat count", got, ne);
    chk(done && !busy && !wr_valid, "R10", "done after last beat",
        {done, busy, wr_valid}, 4);
    if (n > 0) chk(first == lat + 1, "R3", "cycles to first beat", first - 1, lat);
    @(negedge clk);
    chk(done, "R10", "done holds", done, 1);
  endtask

  task automatic t_reset();
    chk(load_ready && !busy && !done && !wr_valid, "R1",
        "reset state ready/busy/done/valid", {load_ready, busy, done, wr_valid}, 8);
  endtask

  task automatic t_u_shape();
    set_run(0, 1, 1, 0, 1, 0);
    set_run(1, 2, 2, 5, 6, 0);
    set_run(2, 1, 2, 0, 6, 1);
    set_run(3, 2, 2, 0, 6, 2);
    load_table(4);
    run_job(4, 0, 0, "R11");   // all four runs must show label 2; clear R7, spans R8
  endtask

  task automatic t_no_conflict_stalls();
    set_run(0, 3, 3, 2, 4, 3);
    set_run(1, 5, 5, 7, 7, 0);
    set_run(2, 1, 1, 0, 0, 2);
    load_table(3);
    run_job(3, 1, 1, "R8");   // stalls R9, ignored start/load R2/R1
  endtask

  task automatic t_chain();
    set_run(0, 1, 1, 0, 0, 0);
    set_run(1, 3, 1, 2, 3, 0);  // conflict: T=3 Q=1, rewrites itself (R6)
    set_run(2, 3, 3, 1, 2, 1);  // id and eq both match T in one step (R5)
    set_run(3, 2, 3, 4, 5, 1);  // eq-only match, later its own conflict (R4)
    set_run(4, 2, 2, 6, 7, 2);
    load_table(5);
    run_job(5, 0, 0, "R5");
  endtask

  task automatic t_empty();
    run_job(0, 1, 0, "R12");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_u_shape();
    t_no_conflict_stalls();
    t_chain();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule